// File: doc/BRIEF.md
# Pipelined 3x3 Rank Filter

This block takes one complete 3x3 neighbourhood of 8-bit unsigned grayscale pixels per clock and returns three order statistics of that neighbourhood: the median, the smallest value and the largest value. A median filter for impulse-noise removal uses the median. Grayscale erosion uses the minimum, and grayscale dilation uses the maximum. Whichever of the three is chosen, it takes the place of the window's centre pixel in the output image. A 2-bit mode presented alongside each window selects which statistic drives the main pixel output. All three statistics are also driven on their own ports at all times.

The ranking is not a full nine-element sort. A fixed network of three-input sorters works in three registered stages. The first stage orders each column. The second stage orders each row of that result. The third stage orders the three values on the anti-diagonal, and the middle of those three is the median. After the second stage, the minimum and the maximum are simply the top-left and bottom-right corners of the array. The window is built upstream, and that logic is outside this block. So are line buffering, image storage, host links and border treatment.

Top module: `rank3_filter`

## Requirements
- R1: `winIn` carries nine unsigned pixels. Pixel k = row*3+col (row 0 on top, col 0 on the left) sits in bits [k*8 +: 8]. For each valid window, `medOut` equals the fifth smallest of the nine values.
- R2: For each valid window, `minOut` equals the smallest of the nine pixels (erosion).
- R3: For each valid window, `maxOut` equals the largest of the nine pixels (dilation).
- R4: `mode` is captured with its window and drives `pixOut` for that same window. Code 0 selects the median, code 1 the minimum, code 2 the maximum, and code 3 the median.
- R5: A window presented with `inValid` high before rising edge n gives its results and `outValid` high after rising edge n+2. That is three registers, with one extra register stage per sorting stage.
- R6: A new window is accepted on every clock. Back-to-back windows with different modes each produce their own result in order.
- R7: Repeated pixel values (ties, all-equal windows, extremes 0 and 255) still give the correct order statistics.
- R8: A synchronous active-high `rst` clears every pipeline stage. After it, `outValid` is 0 and all four pixel outputs are 0.
- R9: A cycle with `inValid` low loads nothing. The window and mode presented in that cycle have no effect, and the outputs keep the last result while `outValid` drops to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | The window and mode on the inputs are valid this cycle |
| mode | input | 2 | Main-output select: 0 median, 1 minimum, 2 maximum, 3 median |
| winIn | input | 72 | Nine 8-bit pixels, pixel k in bits [k*8 +: 8] |
| outValid | output | 1 | The result outputs hold a freshly completed window |
| pixOut | output | 8 | Statistic selected by the window's mode |
| medOut | output | 8 | Window median |
| minOut | output | 8 | Window minimum |
| maxOut | output | 8 | Window maximum |

## Verification
On every cycle, assertions check two things. Each column is in order after stage one, and each row is in order after stage two. Whenever a result is marked valid, minimum ≤ median ≤ maximum and `outValid` follows `inValid` from three edges earlier. These properties show that the network preserves order, but they cannot show that the values are the right ones. The bench therefore checks every output against a reference sort of the nine pixels. It uses windows with ties, extremes and impulse patterns, runs them back to back in all four mode codes, and also checks exact latency, hold during idle cycles, and a reset in the middle of a stream.

// File: rtl/rank3_pkg.sv
package rank3_pkg;

  typedef enum logic [1:0] {
    MODE_MED  = 2'd0,
    MODE_MIN  = 2'd1,
    MODE_MAX  = 2'd2,
    MODE_MED2 = 2'd3
  } mode_t;

  // strobes from control to datapath
  typedef struct packed {
    logic  ld1;      // capture column-sorted window
    logic  ld2;      // capture row-sorted array
    logic  ld3;      // capture result stage
    mode_t selMode;  // mode that belongs to the result stage
  } strb_t;

endpackage

// File: rtl/rank3_sort3.sv
module rank3_sort3 #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] c,
  output logic [W-1:0] lo,
  output logic [W-1:0] mid,
  output logic [W-1:0] hi
);
  logic [W-1:0] abLo, abHi, tmp;

  always_comb begin
    abLo = (a <= b) ? a : b;
    abHi = (a <= b) ? b : a;
    hi   = (abHi >= c) ? abHi : c;
    tmp  = (abHi >= c) ? c : abHi;
    lo   = (abLo <= tmp) ? abLo : tmp;
    mid  = (abLo <= tmp) ? tmp : abLo;
  end
endmodule

// File: rtl/rank3_ctrl.sv
module rank3_ctrl
  import rank3_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        inValid,
  input  logic [1:0]  modeIn,
  output strb_t       strb,
  output logic        outValid
);
  logic  vld1, vld2, vld3;
  mode_t mode1, mode2, mode3;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld1  <= 1'b0;
      vld2  <= 1'b0;
      vld3  <= 1'b0;
      mode1 <= MODE_MED;
      mode2 <= MODE_MED;
      mode3 <= MODE_MED;
    end else begin
      vld1 <= inValid;
      vld2 <= vld1;
      vld3 <= vld2;
      if (inValid) mode1 <= mode_t'(modeIn);
      if (vld1)    mode2 <= mode1;
      if (vld2)    mode3 <= mode2;
    end
  end

  always_comb begin
    strb.ld1     = inValid;
    strb.ld2     = vld1;
    strb.ld3     = vld2;
    strb.selMode = mode3;
    outValid     = vld3;
  end

  assert_latency_R5: assert property (@(posedge clk) disable iff (rst)
    outValid |-> $past(inValid, 3))
    else $error("outValid without a window three edges earlier");

endmodule

// File: rtl/rank3_datapath.sv
module rank3_datapath
  import rank3_pkg::*;
#(
  parameter int PIX_W = 8,
  localparam int DIM   = 3,
  localparam int WIN_W = DIM * DIM * PIX_W
) (
  input  logic             clk,
  input  logic             rst,
  input  strb_t            strb,
  input  logic             outValid,
  input  logic [WIN_W-1:0] winIn,
  output logic [PIX_W-1:0] pixOut,
  output logic [PIX_W-1:0] medOut,
  output logic [PIX_W-1:0] minOut,
  output logic [PIX_W-1:0] maxOut
);
  logic [PIX_W-1:0] colNext [DIM][DIM];
  logic [PIX_W-1:0] colReg  [DIM][DIM];
  logic [PIX_W-1:0] rowNext [DIM][DIM];
  logic [PIX_W-1:0] rowReg  [DIM][DIM];
  logic [PIX_W-1:0] diagLo, diagMid, diagHi;
  logic [PIX_W-1:0] medReg, minReg, maxReg;

  // stage one: order each column top to bottom
  for (genvar c = 0; c < DIM; c++) begin : g_col
    rank3_sort3 #(.W(PIX_W)) u_colSort (
      .a  (winIn[(0*DIM + c)*PIX_W +: PIX_W]),
      .b  (winIn[(1*DIM + c)*PIX_W +: PIX_W]),
      .c  (winIn[(2*DIM + c)*PIX_W +: PIX_W]),
      .lo (colNext[0][c]),
      .mid(colNext[1][c]),
      .hi (colNext[2][c])
    );
  end

  // stage two: order each row left to right
  for (genvar r = 0; r < DIM; r++) begin : g_row
    rank3_sort3 #(.W(PIX_W)) u_rowSort (
      .a  (colReg[r][0]),
      .b  (colReg[r][1]),
      .c  (colReg[r][2]),
      .lo (rowNext[r][0]),
      .mid(rowNext[r][1]),
      .hi (rowNext[r][2])
    );
  end

  // stage three: anti-diagonal median
  rank3_sort3 #(.W(PIX_W)) u_diagSort (
    .a  (rowReg[0][2]),
    .b  (rowReg[1][1]),
    .c  (rowReg[2][0]),
    .lo (diagLo),
    .mid(diagMid),
    .hi (diagHi)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int r = 0; r < DIM; r++) begin
        for (int c = 0; c < DIM; c++) begin
          colReg[r][c] <= '0;
          rowReg[r][c] <= '0;
        end
      end
      medReg <= '0;
      minReg <= '0;
      maxReg <= '0;
    end else begin
      if (strb.ld1) begin
        for (int r = 0; r < DIM; r++)
          for (int c = 0; c < DIM; c++)
            colReg[r][c] <= colNext[r][c];
      end
      if (strb.ld2) begin
        for (int r = 0; r < DIM; r++)
          for (int c = 0; c < DIM; c++)
            rowReg[r][c] <= rowNext[r][c];
      end
      if (strb.ld3) begin
        medReg <= diagMid;
        minReg <= rowReg[0][0];
        maxReg <= rowReg[DIM-1][DIM-1];
      end
    end
  end

  always_comb begin
    medOut = medReg;
    minOut = minReg;
    maxOut = maxReg;
    unique case (strb.selMode)
      MODE_MIN: pixOut = minReg;
      MODE_MAX: pixOut = maxReg;
      default:  pixOut = medReg;
    endcase
  end

  // diagonal extremes are not results of their own
  logic diagUnused;
  assign diagUnused = ^{diagLo, diagHi};

  assert_col_order_R1: assert property (@(posedge clk) disable iff (rst)
    strb.ld2 |-> (colReg[0][0] <= colReg[1][0] && colReg[1][0] <= colReg[2][0] &&
                  colReg[0][1] <= colReg[1][1] && colReg[1][1] <= colReg[2][1] &&
                  colReg[0][2] <= colReg[1][2] && colReg[1][2] <= colReg[2][2]))
    else $error("column stage out of order");

  assert_row_order_R7: assert property (@(posedge clk) disable iff (rst)
    strb.ld3 |-> (rowReg[0][0] <= rowReg[0][1] && rowReg[0][1] <= rowReg[0][2] &&
                  rowReg[1][0] <= rowReg[1][1] && rowReg[1][1] <= rowReg[1][2] &&
                  rowReg[2][0] <= rowReg[2][1] && rowReg[2][1] <= rowReg[2][2]))
    else $error("row stage out of order");

  assert_rank_order_R2: assert property (@(posedge clk) disable iff (rst)
    outValid |-> (minOut <= medOut && medOut <= maxOut))
    else $error("min/median/max out of order");

  assert_hold_idle_R9: assert property (@(posedge clk) disable iff (rst)
    !strb.ld3 |=> ($stable(medOut) && $stable(minOut) && $stable(maxOut)))
    else $error("results moved without a load");

endmodule

// File: rtl/rank3_filter.sv
module rank3_filter
  import rank3_pkg::*;
#(
  parameter int PIX_W = 8,
  localparam int WIN_W = 9 * PIX_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inValid,
  input  logic [1:0]       mode,
  input  logic [WIN_W-1:0] winIn,
  output logic             outValid,
  output logic [PIX_W-1:0] pixOut,
  output logic [PIX_W-1:0] medOut,
  output logic [PIX_W-1:0] minOut,
  output logic [PIX_W-1:0] maxOut
);
  strb_t strb;

  rank3_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .inValid (inValid),
    .modeIn  (mode),
    .strb    (strb),
    .outValid(outValid)
  );

  rank3_datapath #(.PIX_W(PIX_W)) u_dp (
    .clk     (clk),
    .rst     (rst),
    .strb    (strb),
    .outValid(outValid),
    .winIn   (winIn),
    .pixOut  (pixOut),
    .medOut  (medOut),
    .minOut  (minOut),
    .maxOut  (maxOut)
  );

  assert_sel_max_R4: assert property (@(posedge clk) disable iff (rst)
    (outValid && strb.selMode == MODE_MAX) |-> pixOut == maxOut)
    else $error("maximum mode does not drive maximum");

endmodule

// File: tb/rank3_filter_tb.sv
module rank3_filter_tb;

  typedef struct packed {
    logic [71:0] win;
    logic [1:0]  mode;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{72'h09_08_07_06_05_04_03_02_01, 2'd0},
    '{72'h01_02_03_04_05_06_07_08_09, 2'd1},
    '{72'h55_55_55_55_55_55_55_55_55, 2'd2},
    '{72'hFF_00_80_7F_81_00_FF_40_C0, 2'd0},
    '{72'h10_10_20_20_30_30_10_20_30, 2'd3},
    '{72'h00_00_00_00_FF_00_00_00_00, 2'd0},
    '{72'hFF_FF_FF_FF_00_FF_FF_FF_FF, 2'd1},
    '{72'h3C_A5_12_E7_5A_81_C3_24_99, 2'd2},
    '{72'h01_FE_01_FE_01_FE_01_FE_01, 2'd3},
    '{72'h7E_7F_80_7E_7F_80_7E_7F_80, 2'd1}
  };

  logic        clk = 1'b0;
  logic        rst;
  logic        inValid;
  logic [1:0]  mode;
  logic [71:0] winIn;
  logic        outValid;
  logic [7:0]  pixOut, medOut, minOut, maxOut;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk;

  rank3_filter u_dut (
    .clk(clk), .rst(rst), .inValid(inValid), .mode(mode), .winIn(winIn),
    .outValid(outValid), .pixOut(pixOut), .medOut(medOut),
    .minOut(minOut), .maxOut(maxOut)
  );

  function automatic logic [8:0][7:0] sortWin(input logic [71:0] w);
    logic [8:0][7:0] s;
    for (int i = 0; i < 9; i++) s[i] = w[i*8 +: 8];
    for (int i = 1; i < 9; i++) begin
      for (int j = i; j > 0; j--) begin
        if (s[j] < s[j-1]) begin
          logic [7:0] t;
          t = s[j]; s[j] = s[j-1]; s[j-1] = t;
        end
      end
    end
    return s;
  endfunction

  function automatic logic [7:0] pick(input logic [71:0] w, input logic [1:0] m);
    logic [8:0][7:0] s;
    s = sortWin(w);
    case (m)
      2'd1:    return s[0];
      2'd2:    return s[8];
      default: return s[4];
    endcase
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic checkVec(input string req, input vec_t v);
    logic [8:0][7:0] s;
    s = sortWin(v.win);
    chk(req, "outValid", {7'd0, outValid}, 8'd1);
    chk("R1", "median", medOut, s[4]);
    chk("R2", "minimum", minOut, s[0]);
    chk("R3", "maximum", maxOut, s[8]);
    chk("R4", "selected", pixOut, pick(v.win, v.mode));
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] holdMed, holdMin, holdMax, holdPix;
    rst = 1'b1; inValid = 1'b0; mode = 2'd0; winIn = '1;
    repeat (3) @(negedge clk);
    // R8: reset state
    chk("R8", "outValid", {7'd0, outValid}, 8'd0);
    chk("R8", "pixOut", pixOut, 8'd0);
    chk("R8", "medOut", medOut, 8'd0);
    chk("R8", "minOut", minOut, 8'd0);
    chk("R8", "maxOut", maxOut, 8'd0);
    rst = 1'b0;

    // R6/R7: table walked back to back, result for vector n at negedge n+3
    for (int n = 0; n < NV + 3; n++) begin
      if (n >= 3) checkVec("R6", VECS[n-3]);
      if (n < NV) begin
        inValid = 1'b1; winIn = VECS[n].win; mode = VECS[n].mode;
      end else begin
        inValid = 1'b0; winIn = 72'h0; mode = 2'd0;
      end
      @(negedge clk);
    end

    // R9: idle cycles with junk window and mode leave results in place
    holdMed = medOut; holdMin = minOut; holdMax = maxOut; holdPix = pixOut;
    inValid = 1'b0; winIn = 72'hAB_CD_EF_01_23_45_67_89_FE; mode = 2'd2;
    repeat (5) @(negedge clk);
    chk("R9", "outValid idle", {7'd0, outValid}, 8'd0);
    chk("R9", "median held", medOut, holdMed);
    chk("R9", "minimum held", minOut, holdMin);
    chk("R9", "maximum held", maxOut, holdMax);
    chk("R9", "selected held", pixOut, holdPix);

    // R5: single window, exact latency
    inValid = 1'b1; winIn = VECS[7].win; mode = 2'd0;
    @(negedge clk);
    inValid = 1'b0; winIn = '0; mode = 2'd1;
    chk("R5", "valid after 1 edge", {7'd0, outValid}, 8'd0);
    @(negedge clk);
    chk("R5", "valid after 2 edges", {7'd0, outValid}, 8'd0);
    @(negedge clk);
    chk("R5", "valid after 3 edges", {7'd0, outValid}, 8'd1);
    chk("R5", "median at latency", medOut, pick(VECS[7].win, 2'd0));
    chk("R4", "mode captured with window", pixOut, pick(VECS[7].win, 2'd0));
    @(negedge clk);
    chk("R5", "valid one cycle only", {7'd0, outValid}, 8'd0);

    // R8: reset in the middle of a stream
    inValid = 1'b1; winIn = VECS[3].win; mode = 2'd2;
    @(negedge clk);
    winIn = VECS[7].win;
    @(negedge clk);
    rst = 1'b1; inValid = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk("R8", "valid after mid reset", {7'd0, outValid}, 8'd0);
    chk("R8", "pixOut after mid reset", pixOut, 8'd0);
    chk("R8", "maxOut after mid reset", maxOut, 8'd0);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule